// File: doc/BRIEF.md
# Multi-mode 8-bit PWM timer

This block is an 8-bit timer/counter with two waveform outputs. The counter moves one step on each cycle in which a clock-enable tick is high. A 3-bit mode field chooses how it counts. It can run free, clear on a compare value, run single-slope PWM or run dual-slope (phase-correct) PWM. Two compare registers, A and B, each drive a match flag and one waveform output. An overflow flag marks the end of each counting period.

How each output reacts to a match is set by its own 2-bit output-mode field. Each mode has its own rules for four things: where TOP comes from, when new compare values take effect, where the overflow flag sets, and how a compare value equal to TOP is handled in dual-slope counting.

Software uses a small register port. A write port loads the configuration, the counter and the compare values, and clears flags. A registered read port returns register contents one clock after the address is presented.

Top module: `pwm_timer8`

## Requirements
- R1: The mode field selects the counting scheme. 000 is free-running, 001 is dual-slope with TOP=0xFF, 010 is clear-on-compare with TOP=compare A, 011 is single-slope PWM with TOP=0xFF, 101 is dual-slope with TOP=compare A, and 111 is single-slope PWM with TOP=compare A. 100 and 110 behave as free-running.
- R2: The counter changes only on a tick or a counter write. In free-running mode it steps by one on each tick and wraps from 0xFF to 0x00.
- R3: In clear-on-compare and single-slope modes, the tick taken at TOP returns the counter to 0. In dual-slope modes it counts 0 up to TOP, then back down to 0, and repeats with period 2*TOP ticks.
- R4: A compare write takes effect at once in modes 000 and 010. In single-slope modes the active value is replaced on the tick that wraps from TOP to 0. In dual-slope modes it is replaced on the tick taken at TOP.
- R5: The overflow flag sets on the tick taken at 0xFF in modes 000, 010 and 011. It sets on the tick taken at 0 in dual-slope modes, and on the tick taken at TOP in mode 111.
- R6: A match flag sets on the tick in which the counter equals that channel's active compare value. Writing 1 to a flag bit clears only that flag.
- R7: In modes 000 and 010, output mode 01 toggles the output on a match, 10 clears it and 11 sets it.
- R8: In single-slope modes, output mode 10 clears the output on a match and sets it on the wrap tick. 11 does the inverse, and the wrap action wins when both fall on the same tick. 01 does nothing.
- R9: In dual-slope modes, output mode 10 clears on a match while the count is rising and sets on a match while it is falling. 11 does the inverse, and 01 does nothing. The tick at 0 counts as rising; the tick at TOP counts as falling.
- R10: In dual-slope modes, when a channel's compare value equals TOP and its output-mode upper bit is set, matches are ignored. On the tick at TOP the output is set for mode 10 and cleared for mode 11.
- R11: Output mode 00 disconnects the output, which then reads 0 from the next clock on.
- R12: The register addresses are as follows. Address 0 is control: bits 2:0 mode, bit 3 reserved and read as 0, bits 5:4 output mode A, bits 7:6 output mode B. Address 1 is the counter, 2 is compare A and 3 is compare B. Address 4 holds the flags: bit 0 overflow, bit 1 match A, bit 2 match B.
- R13: A counter write blocks compare matches on the next tick.
- R14: Read data is registered and reflects the address presented one clock earlier. All state resets to 0 with the counter counting up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable, one step per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Registered read data |
| count | output | 8 | Current counter value |
| ovf_flag | output | 1 | Overflow flag |
| match_a_flag | output | 1 | Compare A match flag |
| match_b_flag | output | 1 | Compare B match flag |
| wave_a | output | 1 | Waveform output A |
| wave_b | output | 1 | Waveform output B |

## Verification
The wrap property is claimed only for cycles with no register write, since a write may move the counter or the mode in the same cycle as a tick. The properties also assume that dual-slope operation never runs with TOP at zero. The stimulus keeps ticks and register writes in separate cycles, and it loads compare values while the block is still free-running. This makes the active values valid before a buffered mode is selected. No vector uses a TOP of zero.

// File: rtl/pwm_timer8_pkg.sv
`timescale 1ns/1ps
package pwm_timer8_pkg;

  localparam int ADR_W = 3;

  typedef enum logic [2:0] {
    WM_NORMAL    = 3'b000,
    WM_DUAL_FULL = 3'b001,
    WM_CTC       = 3'b010,
    WM_FAST_FULL = 3'b011,
    WM_RSV4      = 3'b100,
    WM_DUAL_A    = 3'b101,
    WM_RSV6      = 3'b110,
    WM_FAST_A    = 3'b111
  } wmode_e;

  typedef enum logic [1:0] {SHAPE_PLAIN, SHAPE_FAST, SHAPE_DUAL} shape_e;

  localparam logic [ADR_W-1:0] ADR_CTRL  = 3'd0;
  localparam logic [ADR_W-1:0] ADR_COUNT = 3'd1;
  localparam logic [ADR_W-1:0] ADR_CMPA  = 3'd2;
  localparam logic [ADR_W-1:0] ADR_CMPB  = 3'd3;
  localparam logic [ADR_W-1:0] ADR_FLAGS = 3'd4;

  function automatic shape_e shape_of(wmode_e m);
    case (m)
      WM_DUAL_FULL, WM_DUAL_A: return SHAPE_DUAL;
      WM_FAST_FULL, WM_FAST_A: return SHAPE_FAST;
      default:                 return SHAPE_PLAIN;
    endcase
  endfunction

  function automatic logic top_from_a(wmode_e m);
    return (m == WM_CTC) || (m == WM_DUAL_A) || (m == WM_FAST_A);
  endfunction

endpackage

// File: rtl/ptm_counter.sv
`timescale 1ns/1ps
module ptm_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             dual,
  input  logic             clamp,
  input  logic [CNT_W-1:0] top,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cnt,
  output logic             blk,
  output logic             going_up,
  output logic             at_top
);
  logic [CNT_W-1:0] cnt_q, nxt;
  logic             up_q, up_nxt, blk_q;

  assign cnt    = cnt_q;
  assign blk    = blk_q;
  assign at_top = (cnt_q == top);

  always_comb begin
    nxt      = cnt_q + 1'b1;
    up_nxt   = 1'b1;
    going_up = 1'b1;
    if (dual) begin
      if (up_q) begin
        going_up = (cnt_q < top);
        if (cnt_q >= top) begin
          nxt    = (cnt_q == '0) ? cnt_q : cnt_q - 1'b1;
          up_nxt = 1'b0;
        end
      end else begin
        going_up = (cnt_q == '0);
        if (cnt_q != '0) begin
          nxt    = cnt_q - 1'b1;
          up_nxt = 1'b0;
        end
      end
    end else if (clamp && at_top) begin
      nxt = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
      blk_q <= 1'b0;
    end else if (ld) begin
      cnt_q <= ld_val;
      blk_q <= 1'b1;
    end else if (tick) begin
      cnt_q <= nxt;
      up_q  <= up_nxt;
      blk_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ptm_cmp_slot.sv
`timescale 1ns/1ps
module ptm_cmp_slot #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             immediate,
  input  logic             latch,
  output logic [CNT_W-1:0] shadow,
  output logic [CNT_W-1:0] live
);
  logic [CNT_W-1:0] shadow_q, live_q;

  assign shadow = shadow_q;
  assign live   = immediate ? shadow_q : live_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      live_q   <= '0;
    end else begin
      if (wr) shadow_q <= wdata;
      if (immediate || latch) live_q <= shadow_q;
    end
  end
endmodule

// File: rtl/ptm_wave.sv
`timescale 1ns/1ps
module ptm_wave
  import pwm_timer8_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  shape_e     shape,
  input  logic [1:0] om,
  input  logic       match,
  input  logic       going_up,
  input  logic       top_tick,
  input  logic       cmp_at_top,
  output logic       wave
);
  logic wave_q, nxt;

  assign wave = wave_q;

  always_comb begin
    nxt = wave_q;
    case (shape)
      SHAPE_FAST: begin
        if (om[1] && match)    nxt = om[0];
        if (om[1] && top_tick) nxt = ~om[0];
      end
      SHAPE_DUAL: begin
        if (om[1]) begin
          if (cmp_at_top) begin
            if (top_tick) nxt = ~om[0];
          end else if (match) begin
            nxt = going_up ? om[0] : ~om[0];
          end
        end
      end
      default: begin
        if (match) begin
          case (om)
            2'b01:   nxt = ~wave_q;
            2'b10:   nxt = 1'b0;
            2'b11:   nxt = 1'b1;
            default: nxt = wave_q;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || om == 2'b00) wave_q <= 1'b0;
    else                    wave_q <= nxt;
  end
endmodule

// File: rtl/pwm_timer8.sv
`timescale 1ns/1ps
module pwm_timer8
  import pwm_timer8_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int N_CH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [2:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic [CNT_W-1:0] count,
  output logic             ovf_flag,
  output logic             match_a_flag,
  output logic             match_b_flag,
  output logic             wave_a,
  output logic             wave_b
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};
  localparam int FLG_W = N_CH + 1;

  wmode_e                      mode_q;
  logic [N_CH-1:0][1:0]        om_q;
  logic [FLG_W-1:0]            flags_q, evt, clr;
  logic [CNT_W-1:0]            rd_q, cnt, top;
  logic [N_CH-1:0][CNT_W-1:0]  live, shadow;
  logic [N_CH-1:0]             match, waves;
  logic                        cnt_blk, going_up, at_top, dual, ovf_evt;

  assign dual = (shape_of(mode_q) == SHAPE_DUAL);
  assign top  = top_from_a(mode_q) ? live[0] : MAXV;

  ptm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .dual(dual),
    .clamp(mode_q == WM_CTC || shape_of(mode_q) == SHAPE_FAST),
    .top(top), .ld(wr_en && wr_addr == ADR_COUNT), .ld_val(wr_data),
    .cnt(cnt), .blk(cnt_blk), .going_up(going_up), .at_top(at_top)
  );

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    localparam logic [2:0] MY_ADR = (ch == 0) ? ADR_CMPA : ADR_CMPB;
    ptm_cmp_slot #(.CNT_W(CNT_W)) u_slot (
      .clk(clk), .rst(rst),
      .wr(wr_en && wr_addr == MY_ADR), .wdata(wr_data),
      .immediate(shape_of(mode_q) == SHAPE_PLAIN),
      .latch(tick && at_top),
      .shadow(shadow[ch]), .live(live[ch])
    );
    assign match[ch] = tick && !cnt_blk && (cnt == live[ch]);
    ptm_wave u_wave (
      .clk(clk), .rst(rst), .shape(shape_of(mode_q)), .om(om_q[ch]),
      .match(match[ch]), .going_up(going_up), .top_tick(tick && at_top),
      .cmp_at_top(live[ch] == top), .wave(waves[ch])
    );
  end

  always_comb begin
    if (dual)                    ovf_evt = tick && (cnt == '0);
    else if (mode_q == WM_FAST_A) ovf_evt = tick && at_top;
    else                         ovf_evt = tick && (cnt == MAXV);
    evt = {match, ovf_evt};
    clr = (wr_en && wr_addr == ADR_FLAGS) ? wr_data[FLG_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= WM_NORMAL;
      om_q    <= '0;
      flags_q <= '0;
      rd_q    <= '0;
    end else begin
      if (wr_en && wr_addr == ADR_CTRL) begin
        mode_q  <= wmode_e'(wr_data[2:0]);
        om_q[0] <= wr_data[5:4];
        om_q[1] <= wr_data[7:6];
      end
      flags_q <= (flags_q & ~clr) | evt;
      case (rd_addr)
        ADR_CTRL:  rd_q <= CNT_W'({om_q[1], om_q[0], 1'b0, mode_q});
        ADR_COUNT: rd_q <= cnt;
        ADR_CMPA:  rd_q <= shadow[0];
        ADR_CMPB:  rd_q <= shadow[1];
        ADR_FLAGS: rd_q <= CNT_W'(flags_q);
        default:   rd_q <= '0;
      endcase
    end
  end

  assign rd_data      = rd_q;
  assign count        = cnt;
  assign ovf_flag     = flags_q[0];
  assign match_a_flag = flags_q[1];
  assign match_b_flag = flags_q[2];
  assign wave_a       = waves[0];
  assign wave_b       = waves[1];
endmodule

// File: rtl/pwm_timer8_chk.sv
`timescale 1ns/1ps
module pwm_timer8_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             wr_en,
  input logic [CNT_W-1:0] count,
  input logic             at_top,
  input logic             blk,
  input logic [2:0]       mode,
  input logic [1:0]       om_a,
  input logic [1:0]       om_b,
  input logic             wave_a,
  input logic             wave_b,
  input logic             ovf_flag,
  input logic             match_a_flag,
  input logic             match_b_flag
);
  // R2
  count_move_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(count) |-> ($past(tick) || $past(wr_en) || $past(rst)));

  // R3
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_en && at_top && (mode == 3'b010 || mode == 3'b011 || mode == 3'b111))
      |=> (count == '0));

  // R5
  ovf_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_flag) |-> $past(tick));

  // R11
  disc_a_chk: assert property (@(posedge clk) disable iff (rst)
    (om_a == 2'b00) |=> !wave_a);

  // R11
  disc_b_chk: assert property (@(posedge clk) disable iff (rst)
    (om_b == 2'b00) |=> !wave_b);

  // R13
  blocked_match_chk: assert property (@(posedge clk) disable iff (rst)
    (blk && tick) |=> (!$rose(match_a_flag) && !$rose(match_b_flag)));
endmodule

bind pwm_timer8 pwm_timer8_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .count(count),
  .at_top(at_top), .blk(cnt_blk), .mode(mode_q), .om_a(om_q[0]), .om_b(om_q[1]),
  .wave_a(wave_a), .wave_b(wave_b), .ovf_flag(ovf_flag),
  .match_a_flag(match_a_flag), .match_b_flag(match_b_flag)
);

// File: tb/pwm_timer8_tb.sv
`timescale 1ns/1ps
module pwm_timer8_tb;
  logic       clk = 1'b0, rst = 1'b1, tick = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  wire  [7:0] rd_data, count;
  wire        ovf_flag, match_a_flag, match_b_flag, wave_a, wave_b;

  int checks = 0, errors = 0;

  pwm_timer8 u_dut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .count(count),
    .ovf_flag(ovf_flag), .match_a_flag(match_a_flag), .match_b_flag(match_b_flag),
    .wave_a(wave_a), .wave_b(wave_b)
  );

  always #2.5 clk = ~clk;

  // row: mode, cmpA, cmpB, omA, omB, ticks
  localparam logic [34:0] ROWS [8] = '{
    {3'd0, 8'd10, 8'd200, 2'b01, 2'b11, 12'd600},
    {3'd1, 8'd64, 8'd128, 2'b10, 2'b11, 12'd1100},
    {3'd2, 8'd20, 8'd7,   2'b01, 2'b11, 12'd100},
    {3'd3, 8'd0,  8'd255, 2'b10, 2'b10, 12'd600},
    {3'd5, 8'd30, 8'd30,  2'b00, 2'b10, 12'd200},
    {3'd5, 8'd40, 8'd0,   2'b00, 2'b10, 12'd200},
    {3'd7, 8'd50, 8'd25,  2'b00, 2'b11, 12'd200},
    {3'd5, 8'd40, 8'd15,  2'b11, 2'b10, 12'd200}
  };

  logic [2:0] mm;
  logic [1:0] moa, mob;
  int  mrc, mp, mT, mcA, mcB;
  bit  mwa, mwb, mov, mma, mmb;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; tick = 1'b0; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic bit is_dual();
    return (mm == 3'd1) || (mm == 3'd5);
  endfunction

  function automatic bit wave_next(input bit w, input logic [1:0] om, input int c,
                                   input bit hit, input bit up, input bit attop);
    bit r = w;
    if (om == 2'b00) return 1'b0;
    if (mm == 3'd0 || mm == 3'd2) begin
      if (hit) r = (om == 2'b01) ? !w : (om == 2'b11);
    end else if (mm == 3'd3 || mm == 3'd7) begin
      if (om[1] && hit)   r = (om == 2'b11);
      if (om[1] && attop) r = (om == 2'b10);
    end else if (om[1]) begin
      if (c == mT) begin
        if (attop) r = (om == 2'b10);
      end else if (hit) begin
        r = up ? (om == 2'b11) : (om == 2'b10);
      end
    end
    return r;
  endfunction

  function automatic string wtag(input logic [1:0] om, input int c);
    if (om == 2'b00) return "R11";
    if (is_dual() && c == mT && om[1]) return "R10";
    if (mm == 3'd0 || mm == 3'd2) return "R7";
    if (mm == 3'd3 || mm == 3'd7) return "R8";
    return "R9";
  endfunction

  task automatic model_step();
    bit ha, hb, attop, up;
    ha = (mrc == mcA); hb = (mrc == mcB); attop = (mrc == mT);
    up = is_dual() ? (mp < mT) : 1'b1;
    if (is_dual())      mov |= (mrc == 0);
    else if (mm == 3'd7) mov |= attop;
    else                mov |= (mrc == 255);
    mma |= ha; mmb |= hb;
    mwa = wave_next(mwa, moa, mcA, ha, up, attop);
    mwb = wave_next(mwb, mob, mcB, hb, up, attop);
    if (is_dual()) begin
      mp  = (mp + 1) % (2 * mT);
      mrc = (mp <= mT) ? mp : 2 * mT - mp;
    end else if (mm == 3'd0) mrc = (mrc + 1) % 256;
    else                     mrc = attop ? 0 : mrc + 1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    @(negedge clk);

    // reset state (R14)
    do_reset();
    chk("R14", "reset count", count, 0);
    chk("R14", "reset flags", {match_b_flag, match_a_flag, ovf_flag}, 0);
    chk("R14", "reset waves", {wave_b, wave_a}, 0);
    rd(3'd0, d);
    chk("R14", "reset ctrl read", d, 0);

    // reserved bit reads zero (R12), read latency (R14)
    wr(3'd0, 8'hFF);
    rd(3'd0, d);
    chk("R12", "ctrl readback", d, 8'hF7);
    wr(3'd2, 8'h5A);
    rd(3'd2, d);
    chk("R12", "cmpA readback", d, 8'h5A);
    rd_addr = 3'd3;
    #1;
    chk("R14", "read before edge", rd_data, 8'h5A);
    @(negedge clk);
    chk("R14", "read after edge", rd_data, 8'h00);

    // vector table
    for (int k = 0; k < 8; k++) begin
      logic [34:0] r;
      int n;
      r = ROWS[k];
      mm = r[34:32]; mcA = r[31:24]; mcB = r[23:16];
      moa = r[15:14]; mob = r[13:12]; n = r[11:0];
      mT = (mm == 3'd2 || mm == 3'd5 || mm == 3'd7) ? mcA : 255;
      mrc = 0; mp = 0; mwa = 0; mwb = 0; mov = 0; mma = 0; mmb = 0;
      do_reset();
      wr(3'd2, 8'(mcA));
      wr(3'd3, 8'(mcB));
      wr(3'd0, {mob, moa, 1'b0, mm});
      tick = 1'b1;
      for (int i = 0; i < n; i++) begin
        @(negedge clk);
        model_step();
        chk((mm == 3'd0) ? "R2" : (mT != 255) ? "R1" : "R3", "count", count, mrc);
        chk("R5", "ovf flag", ovf_flag, mov);
        chk("R6", "match A flag", match_a_flag, mma);
        chk("R6", "match B flag", match_b_flag, mmb);
        chk(wtag(moa, mcA), "wave A", wave_a, mwa);
        chk(wtag(mob, mcB), "wave B", wave_b, mwb);
      end
      tick = 1'b0;
    end

    // counter write blocks match (R13), flag clear (R6)
    do_reset();
    wr(3'd3, 8'd100);
    wr(3'd1, 8'd100);
    ticks(1);
    chk("R13", "blocked count", count, 101);
    chk("R13", "blocked match", match_b_flag, 0);
    wr(3'd1, 8'd99);
    ticks(2);
    chk("R13", "match after block", match_b_flag, 1);
    wr(3'd1, 8'd255);
    ticks(1);
    chk("R2", "wrap to zero", count, 0);
    chk("R5", "ovf at MAX", ovf_flag, 1);
    wr(3'd4, 8'h01);
    chk("R6", "ovf cleared", ovf_flag, 0);
    chk("R6", "match B kept", match_b_flag, 1);

    // buffered update at wrap, single-slope (R4)
    do_reset();
    wr(3'd3, 8'd100);
    wr(3'd0, 8'h03);
    wr(3'd1, 8'd60);
    ticks(1);
    wr(3'd3, 8'd200);
    wr(3'd4, 8'h07);
    ticks(50);
    chk("R4", "fast old value matched", match_b_flag, 1);
    wr(3'd4, 8'h07);
    ticks(100);
    chk("R4", "fast new value not yet live", match_b_flag, 0);
    ticks(45);
    chk("R4", "fast wrapped", count, 0);
    ticks(201);
    chk("R4", "fast new value live", match_b_flag, 1);

    // immediate update, free-running (R4)
    do_reset();
    wr(3'd3, 8'd100);
    wr(3'd1, 8'd60);
    ticks(1);
    wr(3'd3, 8'd200);
    wr(3'd4, 8'h07);
    ticks(50);
    chk("R4", "normal immediate", match_b_flag, 0);

    // latch at TOP, dual-slope (R4)
    do_reset();
    wr(3'd3, 8'd100);
    wr(3'd0, 8'h01);
    wr(3'd1, 8'd60);
    ticks(1);
    wr(3'd3, 8'd50);
    wr(3'd4, 8'h07);
    ticks(50);
    chk("R4", "dual old value matched", match_b_flag, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule